// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block moves single bytes over a two-wire synchronous link, a clock pin and a data pin, and is controlled by a host through a small register window. One control bit picks the direction. As a receiver, the port watches the clock pin. Every rising edge it sees there, after synchronisation, shifts the level of the data pin into an assembly register. The eighth edge copies the assembled byte into the readable data register and raises the serial completion flag. As a transmitter, the port drives both pins itself. An internal 16-bit down-counting timer produces underflow pulses, and the clock pin toggles on each pulse, so one bit takes two underflows. A byte written to the data register is shifted out most significant bit first. The data pin changes only as the clock falls, and the partner samples it as the clock rises.

Completion is reported through an interrupt status register and its mask, not through a busy pin. Reading the status register returns the flags and clears them. The timer underflow also raises a flag of its own. The host bus is a plain register access with one-cycle write and read strobes and has no back-pressure. A byte written while a transmission is in progress waits in a one-byte holding register. Another write before that byte starts replaces it.

Register addresses: 0 = data, 1 = control, 2 = timer latch low byte, 3 = timer latch high byte, 4 = interrupt control.

Top module: `ssp_port`

## Requirements
- R1: In output mode, bits leave most significant first. The data pin changes only in the same cycle that the clock pin falls, and it stays stable while the clock pin is high.
- R2: In output mode with the timer running, a write to the data register (address 0) shifts that byte out. The clock pin idles high and toggles on every timer underflow, giving exactly eight rising edges per byte.
- R3: After the eighth rising clock edge of a transmitted byte, the serial flag, bit 3 of the interrupt status register (address 4), reads as 1.
- R4: In input mode, each rising edge on the clock pin, after a two-flop synchronizer, shifts the data pin in MSB first. After the eighth edge the byte is readable at address 0 and bit 3 is set. Fewer than eight edges set no flag, and the count carries over to the following edges.
- R5: Control bit 0 runs the timer, and starting it loads the counter from the latch. The timer underflows every L cycles for a latch value L of at least 1 and reloads from the latch on each underflow. Each underflow sets status bit 0. In output mode, rising clock edges are 2L cycles apart.
- R6: A latch value of 1 gives the fastest rate, one bit every two system clocks.
- R7: A read of address 4 returns the flags in bits 0 and 3, with bit 7 = 1 when any flag is both set and enabled. The read clears the flags, and a flag set in the same cycle as the read survives it.
- R8: A write to address 4 with bit 7 = 1 sets the mask bits marked by ones in bits 0 to 6. With bit 7 = 0 it clears them. The irq output is high exactly while some enabled flag is set.
- R9: Control bit 6 selects output (1) or input (0). In input mode both pin output enables are low. In output mode both are high.
- R10: A byte written while a transmission is in progress is held and sent right after the current byte, with no lost bits. Changing direction abandons any transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe; clears status when addressing 4 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq | output | 1 | High while any enabled flag is set |
| sclk_i | input | 1 | Serial clock pin, input side |
| sclk_o | output | 1 | Serial clock pin, driven level |
| sclk_oe | output | 1 | Serial clock pin output enable |
| sdat_i | input | 1 | Serial data pin, input side |
| sdat_o | output | 1 | Serial data pin, driven level |
| sdat_oe | output | 1 | Serial data pin output enable |

## Verification
Transmission is tried with the asymmetric byte 0x56 at a slow rate, with 0xA9 at the fastest rate, and with two back-to-back bytes 0x3C and 0xC3. These separate a reversed bit order, a wrong bit period and a lost or reordered held byte. Reception uses 0xA5, a seven-edge partial byte completed by one further edge, and 0x3C and 0x81 under different masks. This shows whether edges are counted across pauses and whether the flag, the summary bit and irq follow the mask. A timer-only run in input mode shows that underflow flags are independent of the shifter.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int DW = 8;
  localparam int TW = 16;
  localparam int NFLAG = 7;

  typedef enum logic [2:0] {
    REG_DATA = 3'd0,
    REG_CTRL = 3'd1,
    REG_TLO  = 3'd2,
    REG_THI  = 3'd3,
    REG_ICR  = 3'd4
  } reg_addr_e;

  localparam int CTRL_RUN = 0;
  localparam int CTRL_OUT = 6;
  localparam int FLG_TMR  = 0;
  localparam int FLG_SER  = 3;
  localparam logic [NFLAG-1:0] FLAG_IMPL = 7'b000_1001;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int W = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/ssp_timer.sv
module ssp_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] latch,
  output logic         uf
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt;

  assign uf = run && !load && (cnt <= ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (load)     cnt <= latch;
    else if (run) begin
      if (cnt <= ONE)  cnt <= latch;
      else             cnt <= cnt - ONE;
    end
  end

  // R5: an underflow always reloads the counter from the latch
  a_r5_reload_on_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> (cnt == $past(latch)));
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_out,
  input  logic         clr,
  input  logic         tick,
  input  logic         wr_byte,
  input  logic [W-1:0] wbyte,
  input  logic         sclk_s,
  input  logic         sdat_s,
  output logic         sclk_q,
  output logic         sdat_q,
  output logic [W-1:0] rx_byte,
  output logic         done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  // transmit side
  logic          busy, pend_v, tx_done;
  logic [W-1:0]  tx_sh, pend_b;
  logic [CW-1:0] tx_cnt;
  logic          finishing;

  assign finishing = mode_out && !clr && busy && tick && !sclk_q && (tx_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; pend_v <= 1'b0; tx_sh <= '0; pend_b <= '0;
      tx_cnt <= '0; sclk_q <= 1'b1; sdat_q <= 1'b1; tx_done <= 1'b0;
    end else begin
      tx_done <= finishing;
      if (clr || !mode_out) begin
        busy <= 1'b0; pend_v <= 1'b0; tx_cnt <= '0; sclk_q <= 1'b1;
      end else if (!busy) begin
        if (wr_byte) begin
          busy <= 1'b1; tx_sh <= wbyte; tx_cnt <= '0;
        end
      end else begin
        if (wr_byte && !finishing) begin
          pend_v <= 1'b1; pend_b <= wbyte;
        end
        if (tick) begin
          if (sclk_q) begin
            sclk_q <= 1'b0;
            sdat_q <= tx_sh[W-1];
            tx_sh  <= {tx_sh[W-2:0], 1'b0};
          end else begin
            sclk_q <= 1'b1;
            if (tx_cnt == LAST) begin
              tx_cnt <= '0;
              if (pend_v) begin
                tx_sh <= pend_b;
                if (wr_byte) pend_b <= wbyte;
                else         pend_v <= 1'b0;
              end else if (wr_byte) begin
                tx_sh <= wbyte;
              end else begin
                busy <= 1'b0;
              end
            end else begin
              tx_cnt <= tx_cnt + 1'b1;
            end
          end
        end
      end
    end
  end

  // receive side
  logic          s_prev, rx_done, rise;
  logic [W-1:0]  rx_sh;
  logic [CW-1:0] rx_cnt;

  assign rise = sclk_s && !s_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_prev <= 1'b0; rx_sh <= '0; rx_cnt <= '0; rx_byte <= '0; rx_done <= 1'b0;
    end else begin
      s_prev  <= sclk_s;
      rx_done <= 1'b0;
      if (clr || mode_out) begin
        rx_cnt <= '0;
      end else if (rise) begin
        rx_sh <= {rx_sh[W-2:0], sdat_s};
        if (rx_cnt == LAST) begin
          rx_cnt  <= '0;
          rx_byte <= {rx_sh[W-2:0], sdat_s};
          rx_done <= 1'b1;
        end else begin
          rx_cnt <= rx_cnt + 1'b1;
        end
      end
    end
  end

  assign done = tx_done | rx_done;

  // R1: the data pin only moves together with a falling clock
  a_r1_data_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdat_q) |-> $fell(sclk_q));
  // R3: transmit completion is reported with the clock back at idle high
  a_r3_done_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> sclk_q);
  // R4: a received byte completes only after a qualified rising edge
  a_r4_rx_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(rise && !mode_out && !clr));
endmodule

// File: rtl/ssp_irq.sv
module ssp_irq #(
  parameter int NF = 7,
  parameter logic [NF-1:0] IMPL = 7'b000_1001,
  parameter int SER_BIT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set,
  input  logic          rd_clr,
  input  logic          mask_wr,
  input  logic [NF:0]   wdata,
  output logic [NF:0]   status,
  output logic          irq
);
  logic [NF-1:0] flag, mask;

  for (genvar i = 0; i < NF; i++) begin : g_bit
    if (IMPL[i]) begin : g_on
      logic f_q, m_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          f_q <= 1'b0; m_q <= 1'b0;
        end else begin
          f_q <= set[i] | (f_q & ~rd_clr);
          if (mask_wr && wdata[i]) m_q <= wdata[NF];
        end
      end
      assign flag[i] = f_q;
      assign mask[i] = m_q;
    end else begin : g_off
      assign flag[i] = 1'b0;
      assign mask[i] = 1'b0;
    end
  end

  assign irq    = |(flag & mask);
  assign status = {irq, flag};

  // R7: reading the status clears the serial flag unless it is set again
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !set[SER_BIT]) |=> !flag[SER_BIT]);
endmodule

// File: rtl/ssp_port.sv
module ssp_port
  import ssp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  input  logic          sclk_i,
  output logic          sclk_o,
  output logic          sclk_oe,
  input  logic          sdat_i,
  output logic          sdat_o,
  output logic          sdat_oe
);
  logic [DW-1:0] ctrl_q;
  logic [TW-1:0] latch_q;
  logic wr_data, wr_ctrl, wr_icr, rd_icr;
  logic mode_out, mode_chg, tmr_load, uf, sp_done;
  logic [1:0] pins_s;
  logic [DW-1:0] rx_byte;
  logic [NFLAG-1:0] set_v;
  logic [NFLAG:0] status;

  assign wr_data  = bus_wr && (bus_addr == REG_DATA);
  assign wr_ctrl  = bus_wr && (bus_addr == REG_CTRL);
  assign wr_icr   = bus_wr && (bus_addr == REG_ICR);
  assign rd_icr   = bus_rd && (bus_addr == REG_ICR);
  assign mode_out = ctrl_q[CTRL_OUT];
  assign mode_chg = wr_ctrl && (bus_wdata[CTRL_OUT] != ctrl_q[CTRL_OUT]);
  assign tmr_load = wr_ctrl && bus_wdata[CTRL_RUN] && !ctrl_q[CTRL_RUN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      latch_q <= '1;
    end else if (bus_wr) begin
      case (bus_addr)
        REG_CTRL: ctrl_q          <= bus_wdata;
        REG_TLO:  latch_q[7:0]    <= bus_wdata;
        REG_THI:  latch_q[TW-1:8] <= bus_wdata[TW-9:0];
        default: ;
      endcase
    end
  end

  ssp_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q[CTRL_RUN]), .load(tmr_load),
    .latch(latch_q), .uf(uf)
  );

  ssp_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sclk_i, sdat_i}), .q(pins_s)
  );

  ssp_shifter #(.W(DW)) u_shf (
    .clk(clk), .rst_n(rst_n), .mode_out(mode_out), .clr(mode_chg),
    .tick(uf), .wr_byte(wr_data), .wbyte(bus_wdata),
    .sclk_s(pins_s[1]), .sdat_s(pins_s[0]),
    .sclk_q(sclk_o), .sdat_q(sdat_o), .rx_byte(rx_byte), .done(sp_done)
  );

  always_comb begin
    set_v          = '0;
    set_v[FLG_TMR] = uf;
    set_v[FLG_SER] = sp_done;
  end

  ssp_irq #(.NF(NFLAG), .IMPL(FLAG_IMPL), .SER_BIT(FLG_SER)) u_irq (
    .clk(clk), .rst_n(rst_n), .set(set_v), .rd_clr(rd_icr),
    .mask_wr(wr_icr), .wdata(bus_wdata), .status(status), .irq(irq)
  );

  always_comb begin
    case (bus_addr)
      REG_DATA: bus_rdata = rx_byte;
      REG_CTRL: bus_rdata = ctrl_q;
      REG_TLO:  bus_rdata = latch_q[7:0];
      REG_THI:  bus_rdata = latch_q[TW-1:8];
      REG_ICR:  bus_rdata = status;
      default:  bus_rdata = '0;
    endcase
  end

  assign sclk_oe = mode_out;
  assign sdat_oe = mode_out;
endmodule

// File: tb/sim_ssp_port.sv
module sim_ssp_port;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, bus_wr, bus_rd, irq, sclk_i, sclk_o, sclk_oe, sdat_i, sdat_o, sdat_oe;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  ssp_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
    .sdat_i(sdat_i), .sdat_o(sdat_o), .sdat_oe(sdat_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // watch the driven pins; record bits at rising clock edges
  task automatic collect(input int n, output logic [15:0] bits, output int period,
                         output int bad);
    logic pc, pd;
    int t = 0, got = 0, first = 0, second = 0;
    bits = '0; bad = 0; pc = sclk_o; pd = sdat_o;
    while (got < n && t < 4000) begin
      @(negedge clk); t++;
      if (sdat_o !== pd && !(pc === 1'b1 && sclk_o === 1'b0)) bad++;
      if (pc === 1'b0 && sclk_o === 1'b1) begin
        bits = {bits[14:0], sdat_o}; got++;
        if (got == 1) first = t;
        if (got == 2) second = t;
      end
      pc = sclk_o; pd = sdat_o;
    end
    period = second - first;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdat_i = b[i];
      repeat (3) @(negedge clk);
      sclk_i = 1'b1;
      repeat (3) @(negedge clk);
      sclk_i = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(3'd1, d); chk("R9 reset ctrl", d, 8'h00);
    rd(3'd4, d); chk("R7 reset status", d, 8'h00);
    chk("R8 reset irq", irq, 0);
    chk("R9 clk pin released", sclk_oe, 0);
    chk("R9 data pin released", sdat_oe, 0);
  endtask

  task automatic t_out_basic();
    logic [15:0] b; int p, bad; logic [7:0] d;
    wr(3'd3, 8'h00); wr(3'd2, 8'h04); wr(3'd1, 8'h41);
    chk("R9 pins driven in output", {sclk_oe, sdat_oe}, 2'b11);
    rd(3'd4, d);
    wr(3'd0, 8'h56);
    collect(8, b, p, bad);
    chk("R2 byte 0x56 sent MSB first", b[7:0], 8'h56);
    chk("R5 rise spacing 2L for L=4", p, 8);
    chk("R1 data moves only on fall", bad, 0);
    repeat (4) @(negedge clk);
    rd(3'd4, d);
    chk("R3 serial flag after 8 bits", d[3], 1);
    chk("R5 timer flag set", d[0], 1);
  endtask

  task automatic t_fast();
    logic [15:0] b; int p, bad;
    wr(3'd2, 8'h01);
    repeat (10) @(negedge clk);
    wr(3'd0, 8'hA9);
    collect(8, b, p, bad);
    chk("R6 byte 0xA9 at fastest rate", b[7:0], 8'hA9);
    chk("R6 one bit per two clocks", p, 2);
    chk("R1 data stable at fast rate", bad, 0);
  endtask

  task automatic t_buffer();
    logic [15:0] b; int p, bad; logic [7:0] d;
    wr(3'd2, 8'h02);
    repeat (6) @(negedge clk);
    rd(3'd4, d);
    wr(3'd0, 8'h3C); wr(3'd0, 8'hC3);
    collect(16, b, p, bad);
    chk("R10 held byte follows", b, 16'h3CC3);
    chk("R1 data stable back to back", bad, 0);
    repeat (3) @(negedge clk);
    rd(3'd4, d);
    chk("R3 flag after held byte", d[3], 1);
  endtask

  task automatic t_in();
    logic [7:0] d;
    wr(3'd1, 8'h00);
    chk("R9 pins released in input", {sclk_oe, sdat_oe}, 2'b00);
    repeat (3) @(negedge clk);
    rd(3'd4, d);
    send_bits(8'hA5, 8);
    rd(3'd4, d); chk("R4 flag after received byte", d, 8'h08);
    rd(3'd4, d); chk("R7 status cleared by read", d, 8'h00);
    rd(3'd0, d); chk("R4 received 0xA5", d, 8'hA5);
    send_bits(8'hFF, 7);
    rd(3'd4, d); chk("R4 no flag after 7 edges", d, 8'h00);
    send_bits(8'h00, 1);
    rd(3'd4, d); chk("R4 flag after eighth edge", d[3], 1);
    rd(3'd0, d); chk("R4 partial byte completed 0xFE", d, 8'hFE);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    wr(3'd4, 8'h88);
    send_bits(8'h3C, 8);
    chk("R8 irq with enabled flag", irq, 1);
    rd(3'd4, d); chk("R7 summary bit with flag", d, 8'h88);
    chk("R7 irq drops after read", irq, 0);
    wr(3'd4, 8'h08);
    send_bits(8'h81, 8);
    chk("R8 masked flag gives no irq", irq, 0);
    rd(3'd4, d); chk("R8 flag without summary", d, 8'h08);
    rd(3'd0, d); chk("R4 received 0x81", d, 8'h81);
  endtask

  task automatic t_timer();
    logic [7:0] d;
    wr(3'd2, 8'h05); wr(3'd3, 8'h00);
    wr(3'd4, 8'h81);
    wr(3'd1, 8'h01);
    repeat (12) @(negedge clk);
    chk("R5 timer flag raises irq", irq, 1);
    rd(3'd4, d); chk("R5 timer flag only", d & 8'h0F, 8'h01);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    sclk_i = 1'b0; sdat_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_out_basic();
    t_fast();
    t_buffer();
    t_in();
    t_irq();
    t_timer();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule